// File: doc/BRIEF.md
# Interleaved Reed-Solomon Link Frame Encoder

This block assembles the transmit frame for a radiation-tolerant serial link. On each cycle where the frame strobe is high it captures a 4-bit slow-control field and an 80-bit user payload. It puts a 4-bit header in front of them that marks the frame as data or as idle. The resulting 88 bits are 22 four-bit symbols. The encoder deals them alternately into two Reed-Solomon (15,11) codewords over GF(16). It computes four parity symbols for each codeword and emits a single 120-bit frame. Any corrupted run of up to eight neighbouring symbols therefore lands at most four times in either codeword.

The message symbols keep their natural order at the top of the frame. The eight parity symbols follow, alternating between the two codewords. Every frame symbol belongs to the codeword selected by its index parity, so a downstream decoder can separate the codewords again with no reordering table. The encoder has two register stages: one captures the inputs, and one holds the finished frame. A frame strobe therefore produces a valid output exactly two clock edges later. The output frame holds its last value while no new frame arrives.

Top module: `fec_frame_encoder`

## Requirements
- R1: The header field, out_frame[119:116], is 4'b0101 when in_idle was 0 at capture and 4'b0110 when in_idle was 1.
- R2: out_frame[115:112] carries the captured in_sc and out_frame[111:32] carries the captured in_data, bit for bit.
- R3: out_valid is high in exactly those cycles that follow, by two rising clock edges, a rising edge at which in_valid was high. Consecutive strobes give consecutive valid frames.
- R4: Frame symbol j (j = 0..29) occupies out_frame[119-4j -: 4]. Even j belong to codeword A and odd j to codeword B. Read from the lowest j upward, each codeword's 15 symbols are the coefficients of x^14 down to x^0. Each codeword evaluates to zero at alpha^1, alpha^2, alpha^3 and alpha^4, where alpha = 4'h2 in GF(16) with field polynomial x^4+x+1.
- R5: Parity symbol p (p = 0..3) of codeword l (A = 0, B = 1) sits at frame symbol 22+2p+l. Parity symbol p is the coefficient of x^(3-p) in the remainder of m(x)*x^4 divided by (x+alpha)(x+alpha^2)(x+alpha^3)(x+alpha^4). An all-zero payload and slow-control field under the data header gives all-zero parity for codeword B and non-zero parity for codeword A.
- R6: Changing only the message symbol at an even index changes all four parity symbols of codeword A and leaves every parity symbol of codeword B unchanged. The reverse holds for odd indices, so any eight consecutive frame symbols hold four symbols of each codeword.
- R7: In cycles where out_valid is low, out_frame keeps its previous value, whatever is applied on the data inputs while in_valid is low.
- R8: An active-low rst_n clears out_valid and out_frame to zero at once, without waiting for a clock edge, and holds them at zero while it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame strobe; inputs are captured at the rising edge where it is high |
| in_idle | input | 1 | Header select: 0 data header, 1 idle header |
| in_sc | input | 4 | Slow-control field |
| in_data | input | 80 | User payload |
| out_valid | output | 1 | Output frame valid, two edges after the strobe |
| out_frame | output | 120 | Encoded, interleaved frame |

## Verification
The assertions assume that every input, including in_idle and the payload, is at a defined level at each rising edge after reset. They assume that rst_n is low from time zero, so that their history registers start at the same point as the design. They assume that nothing in the encoding depends on gaps between strobes. The bench changes every input only on the falling edge and keeps rst_n low across the first edges. It mixes random strobe densities, including long back-to-back runs and idle stretches with random payload, so that the assumed conditions hold while all header and timing combinations occur.

// File: rtl/fec_enc_pkg.sv
package fec_enc_pkg;

    parameter int SYM_W    = 4;
    parameter int MSG_SYMS = 11;
    parameter int PAR_SYMS = 4;
    parameter int LANES    = 2;
    parameter int HDR_W    = 4;
    parameter int SC_W     = 4;
    parameter int DATA_W   = 80;

    parameter logic [SYM_W:0]   FIELD_POLY = 5'b10011;
    parameter logic [SYM_W-1:0] ALPHA      = 4'h2;
    parameter logic [HDR_W-1:0] HDR_DATA   = 4'b0101;
    parameter logic [HDR_W-1:0] HDR_IDLE   = 4'b0110;

    localparam int TOT_MSG    = LANES * MSG_SYMS;
    localparam int FRAME_SYMS = LANES * (MSG_SYMS + PAR_SYMS);
    localparam int MSG_W      = TOT_MSG * SYM_W;
    localparam int FRAME_W    = FRAME_SYMS * SYM_W;
    localparam int LANE_MSG_W = MSG_SYMS * SYM_W;
    localparam int LANE_PAR_W = PAR_SYMS * SYM_W;

    typedef struct packed {
        logic               s1_valid;
        logic [MSG_W-1:0]   s1_msg;
        logic               out_valid;
        logic [FRAME_W-1:0] out_frame;
    } enc_state_t;

    // GF(2^SYM_W) product by shift-and-add with modular reduction
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
        end
        return acc;
    endfunction

    // Low-order coefficients of prod (x + alpha^i), i = 1..PAR_SYMS; leading 1 implied
    function automatic logic [LANE_PAR_W-1:0] gen_coefs();
        logic [SYM_W-1:0]      g [PAR_SYMS+1];
        logic [SYM_W-1:0]      root;
        logic [LANE_PAR_W-1:0] flat;
        for (int j = 0; j <= PAR_SYMS; j++) g[j] = '0;
        g[0] = SYM_W'(1);
        root = SYM_W'(1);
        for (int i = 0; i < PAR_SYMS; i++) begin
            root = gf_mul(root, ALPHA);
            for (int j = PAR_SYMS; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
        end
        for (int j = 0; j < PAR_SYMS; j++) flat[j*SYM_W +: SYM_W] = g[j];
        return flat;
    endfunction

endpackage

// File: rtl/rs_parity_calc.sv
module rs_parity_calc
    import fec_enc_pkg::*;
#(
    parameter int K = MSG_SYMS
) (
    input  logic [K*SYM_W-1:0]    msg_i,
    output logic [LANE_PAR_W-1:0] par_o
);

    localparam logic [LANE_PAR_W-1:0] GCOEF = gen_coefs();

    // Unrolled division register: one feedback step per message symbol
    always_comb begin
        logic [SYM_W-1:0] rem [PAR_SYMS];
        logic [SYM_W-1:0] fb;
        for (int j = 0; j < PAR_SYMS; j++) rem[j] = '0;
        for (int k = 0; k < K; k++) begin
            fb = msg_i[(K-1-k)*SYM_W +: SYM_W] ^ rem[PAR_SYMS-1];
            for (int j = PAR_SYMS-1; j > 0; j--)
                rem[j] = rem[j-1] ^ gf_mul(fb, GCOEF[j*SYM_W +: SYM_W]);
            rem[0] = gf_mul(fb, GCOEF[SYM_W-1:0]);
        end
        for (int j = 0; j < PAR_SYMS; j++) par_o[j*SYM_W +: SYM_W] = rem[j];
    end

endmodule

// File: rtl/symbol_weave.sv
module symbol_weave
    import fec_enc_pkg::*;
(
    input  logic [MSG_W-1:0]                  msg_i,
    input  logic [LANES-1:0][LANE_PAR_W-1:0]  lane_par_i,
    output logic [LANES-1:0][LANE_MSG_W-1:0]  lane_msg_o,
    output logic [FRAME_W-1:0]                frame_o
);

    // Message symbol k goes to lane k % LANES and stays at frame slot k
    for (genvar k = 0; k < TOT_MSG; k++) begin : g_msg
        localparam int LN  = k % LANES;
        localparam int POS = k / LANES;
        assign lane_msg_o[LN][(MSG_SYMS-1-POS)*SYM_W +: SYM_W] =
            msg_i[(TOT_MSG-1-k)*SYM_W +: SYM_W];
        assign frame_o[(FRAME_SYMS-1-k)*SYM_W +: SYM_W] =
            msg_i[(TOT_MSG-1-k)*SYM_W +: SYM_W];
    end

    // Parity symbols alternate between lanes after the message
    for (genvar q = 0; q < LANES*PAR_SYMS; q++) begin : g_par
        localparam int LN = q % LANES;
        localparam int PI = q / LANES;
        assign frame_o[(FRAME_SYMS-1-TOT_MSG-q)*SYM_W +: SYM_W] =
            lane_par_i[LN][(PAR_SYMS-1-PI)*SYM_W +: SYM_W];
    end

endmodule

// File: rtl/fec_frame_encoder.sv
module fec_frame_encoder
    import fec_enc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_idle,
    input  logic [SC_W-1:0]    in_sc,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_valid,
    output logic [FRAME_W-1:0] out_frame
);

    enc_state_t st_d, st_q;

    logic [LANES-1:0][LANE_MSG_W-1:0] lane_msg;
    logic [LANES-1:0][LANE_PAR_W-1:0] lane_par;
    logic [FRAME_W-1:0]               woven;

    symbol_weave u_weave (
        .msg_i      (st_q.s1_msg),
        .lane_par_i (lane_par),
        .lane_msg_o (lane_msg),
        .frame_o    (woven)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rs_parity_calc #(.K(MSG_SYMS)) u_rs (
            .msg_i (lane_msg[l]),
            .par_o (lane_par[l])
        );
    end

    always_comb begin
        st_d           = st_q;
        st_d.s1_valid  = in_valid;
        if (in_valid)
            st_d.s1_msg = {(in_idle ? HDR_IDLE : HDR_DATA), in_sc, in_data};
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid)
            st_d.out_frame = woven;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_frame = st_q.out_frame;

endmodule

// File: rtl/fec_frame_encoder_chk.sv
module fec_frame_encoder_chk
    import fec_enc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_idle,
    input logic [SC_W-1:0]    in_sc,
    input logic [DATA_W-1:0]  in_data,
    input logic               out_valid,
    input logic [FRAME_W-1:0] out_frame
);

    logic [1:0]                  v_sh;
    logic [1:0]                  idle_sh;
    logic [1:0][SC_W+DATA_W-1:0] pay_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_sh    <= '0;
            idle_sh <= '0;
            pay_sh  <= '0;
        end else begin
            v_sh    <= {v_sh[0], in_valid};
            idle_sh <= {idle_sh[0], in_idle};
            pay_sh  <= {pay_sh[0], {in_sc, in_data}};
        end
    end

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_frame == '0));

    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sh[1]);

    assert_header_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_frame[FRAME_W-1 -: HDR_W] == (idle_sh[1] ? HDR_IDLE : HDR_DATA));

    assert_payload_place_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_frame[FRAME_W-HDR_W-1 -: SC_W+DATA_W] == pay_sh[1]);

    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_frame));

endmodule

bind fec_frame_encoder fec_frame_encoder_chk u_chk (.*);

// File: tb/sim_fec_frame_encoder.sv
module sim_fec_frame_encoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_idle = 1'b0;
    logic [3:0]   in_sc = '0;
    logic [79:0]  in_data = '0;
    logic         out_valid;
    logic [119:0] out_frame;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit           hv [2];
    bit           hi [2];
    logic [3:0]   hsc [2];
    logic [79:0]  hd [2];
    logic [119:0] held;
    logic [119:0] seen0, seen1;
    logic [3:0]   gb [5];

    fec_frame_encoder u0 (.*);

    always #10 clk = ~clk;

    function automatic logic [3:0] b_mul(input logic [3:0] a, input logic [3:0] b);
        logic [6:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (7'(a) << i);
        for (int i = 6; i >= 4; i--) if (p[i]) p = p ^ (7'(5'b10011) << (i - 4));
        return p[3:0];
    endfunction

    function automatic logic [3:0] b_pow(input int e);
        logic [3:0] r;
        r = 4'h1;
        for (int i = 0; i < e; i++) r = b_mul(r, 4'h2);
        return r;
    endfunction

    function automatic logic [3:0] fsym(input logic [119:0] f, input int j);
        return f[(29-j)*4 +: 4];
    endfunction

    // Remainder of m(x) x^4 / g(x) by explicit long division
    function automatic logic [15:0] b_parity(input logic [43:0] m);
        logic [3:0] c [15];
        logic [3:0] q;
        for (int i = 0; i < 15; i++) c[i] = '0;
        for (int i = 0; i < 11; i++) c[14-i] = m[(10-i)*4 +: 4];
        for (int deg = 14; deg >= 4; deg--) begin
            q = c[deg];
            for (int t = 0; t <= 4; t++) c[deg-4+t] = c[deg-4+t] ^ b_mul(q, gb[t]);
        end
        return {c[3], c[2], c[1], c[0]};
    endfunction

    function automatic logic [119:0] model_frame(input bit idl, input logic [3:0] sc,
                                                 input logic [79:0] d);
        logic [87:0]  msg;
        logic [43:0]  lm [2];
        logic [15:0]  lp [2];
        logic [119:0] f;
        msg = {(idl ? 4'b0110 : 4'b0101), sc, d};
        for (int l = 0; l < 2; l++) begin
            for (int i = 0; i < 11; i++)
                lm[l][(10-i)*4 +: 4] = msg[(21-(2*i+l))*4 +: 4];
            lp[l] = b_parity(lm[l]);
        end
        f = {msg, 32'h0};
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 2; l++)
                f[(29-(22+2*p+l))*4 +: 4] = lp[l][(3-p)*4 +: 4];
        return f;
    endfunction

    function automatic logic [3:0] syndrome(input logic [119:0] f, input int l, input int e);
        logic [3:0] acc, x;
        x = b_pow(e);
        acc = '0;
        for (int n = 0; n < 15; n++) acc = b_mul(acc, x) ^ fsym(f, 2*n + l);
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [119:0] act, input logic [119:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [119:0] exp;
        chk(out_valid == hv[1], "R3", "out_valid timing", 120'(out_valid), 120'(hv[1]));
        if (hv[1]) begin
            exp = model_frame(hi[1], hsc[1], hd[1]);
            chk(out_frame[119:116] == exp[119:116], "R1", "header",
                120'(out_frame[119:116]), 120'(exp[119:116]));
            chk(out_frame[115:32] == exp[115:32], "R2", "sc and data field",
                120'(out_frame[115:32]), 120'(exp[115:32]));
            chk(out_frame[31:0] == exp[31:0], "R5", "parity by long division",
                120'(out_frame[31:0]), 120'(exp[31:0]));
            for (int l = 0; l < 2; l++)
                for (int e = 1; e <= 4; e++)
                    chk(syndrome(out_frame, l, e) == 4'h0, "R4", "codeword syndrome",
                        120'(syndrome(out_frame, l, e)), 120'h0);
            held  = out_frame;
            seen0 = seen1;
            seen1 = out_frame;
        end else begin
            chk(out_frame == held, "R7", "frame held without strobe", out_frame, held);
        end
    endtask

    task automatic step(input bit v, input bit idl, input logic [3:0] sc, input logic [79:0] d);
        @(negedge clk);
        check_outputs();
        hv[1] = hv[0];   hv[0] = v;
        hi[1] = hi[0];   hi[0] = idl;
        hsc[1] = hsc[0]; hsc[0] = sc;
        hd[1] = hd[0];   hd[0] = d;
        in_valid = v;
        in_idle  = idl;
        in_sc    = sc;
        in_data  = d;
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 2; i++) begin
            hv[i] = 1'b0; hi[i] = 1'b0; hsc[i] = '0; hd[i] = '0;
        end
        held = '0;
    endtask

    function automatic logic [79:0] rnd80();
        return {$urandom(), $urandom(), 16'($urandom())};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog expired before the run completed");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [79:0] xd;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0c0d);
        for (int t = 0; t <= 4; t++) gb[t] = '0;
        gb[0] = 4'h1;
        for (int i = 1; i <= 4; i++) begin
            for (int t = 4; t > 0; t--) gb[t] = gb[t-1] ^ b_mul(gb[t], b_pow(i));
            gb[0] = b_mul(gb[0], b_pow(i));
        end
        clear_hist();
        seen0 = '0;
        seen1 = '0;

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_frame == '0, "R8", "state during reset",
            out_frame, 120'h0);
        rst_n = 1'b1;

        // R5: all-zero payload under the data header
        step(1'b1, 1'b0, 4'h0, 80'h0);
        step(1'b0, 1'b0, 4'h0, 80'h0);
        step(1'b0, 1'b0, 4'h0, 80'h0);
        chk(seen1[31:0] != '0, "R5", "zero payload frame captured", seen1, 120'h0);
        for (int p = 0; p < 4; p++)
            chk(fsym(seen1, 23 + 2*p) == 4'h0, "R5", "zero payload lane B parity",
                120'(fsym(seen1, 23 + 2*p)), 120'h0);

        // R1: idle header with all-ones payload, then back-to-back strobes (R3)
        step(1'b1, 1'b1, 4'hF, {80{1'b1}});
        step(1'b1, 1'b0, 4'hA, 80'h0123_4567_89AB_CDEF_0F1E);
        step(1'b1, 1'b1, 4'h5, rnd80());
        step(1'b0, 1'b0, 4'h3, rnd80());

        // R7: garbage on the data inputs while the strobe is low
        for (int i = 0; i < 6; i++) step(1'b0, 1'($urandom()), 4'($urandom()), rnd80());

        // R6: change only message symbol 4 (lane A), then only symbol 5 (lane B)
        xd = rnd80();
        step(1'b1, 1'b0, 4'h7, xd);
        step(1'b1, 1'b0, 4'h7, xd ^ (80'h9 << 68));
        step(1'b0, 1'b0, 4'h0, 80'h0);
        step(1'b0, 1'b0, 4'h0, 80'h0);
        for (int p = 0; p < 4; p++) begin
            chk(fsym(seen0, 22 + 2*p) != fsym(seen1, 22 + 2*p), "R6", "lane A parity moved",
                120'(fsym(seen1, 22 + 2*p)), 120'(fsym(seen0, 22 + 2*p)));
            chk(fsym(seen0, 23 + 2*p) == fsym(seen1, 23 + 2*p), "R6", "lane B parity kept",
                120'(fsym(seen1, 23 + 2*p)), 120'(fsym(seen0, 23 + 2*p)));
        end
        step(1'b1, 1'b0, 4'h7, xd);
        step(1'b1, 1'b0, 4'h7, xd ^ (80'hC << 64));
        step(1'b0, 1'b0, 4'h0, 80'h0);
        step(1'b0, 1'b0, 4'h0, 80'h0);
        for (int p = 0; p < 4; p++) begin
            chk(fsym(seen0, 22 + 2*p) == fsym(seen1, 22 + 2*p), "R6", "lane A parity kept",
                120'(fsym(seen1, 22 + 2*p)), 120'(fsym(seen0, 22 + 2*p)));
            chk(fsym(seen0, 23 + 2*p) != fsym(seen1, 23 + 2*p), "R6", "lane B parity moved",
                120'(fsym(seen1, 23 + 2*p)), 120'(fsym(seen0, 23 + 2*p)));
        end

        // Random traffic with varying strobe density
        for (int i = 0; i < 400; i++) begin
            bit v;
            v = (i < 200) ? (($urandom() % 4) != 0) : (($urandom() % 4) == 0);
            step(v, 1'($urandom()), 4'($urandom()), rnd80());
        end

        // R8: asynchronous reset with the pipeline full
        step(1'b1, 1'b0, 4'h1, rnd80());
        step(1'b1, 1'b1, 4'h2, rnd80());
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(out_valid == 1'b0 && out_frame == '0, "R8", "immediate clear", out_frame, 120'h0);
        in_valid = 1'b0;
        clear_hist();
        @(negedge clk);
        chk(out_valid == 1'b0 && out_frame == '0, "R8", "held in reset", out_frame, 120'h0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 4'h9, rnd80());
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'h0, 80'h0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule